// File: doc/BRIEF.md
# Pulse-Duration Item Transmitter

This block plays a list of 32-bit pulse items, held in a local item memory, onto one output pin. Each item holds two phases, and each phase has an output level and a duration. The first phase is played and then the second. Durations count ticks of a programmable clock divider. A zero duration stops playback. An optional carrier can be gated onto the phases whose level matches a chosen carrier level. When no playback is running, the pin rests at a programmable idle level.

Software fills the memory through a write port. The write pointer advances by one on each write and has its own reset pulse. Playback starts from the current read pointer when the start strobe is given. In continuous mode the read pointer wraps from the last word of memory back to word 0, so software can refill one half of the memory while the other half plays. An item-count threshold event signals when it is safe to refill. Three sticky events are kept: end, threshold and error. Each has an enable and a write-1-to-clear input, and together they drive one interrupt line.

The sequencer is a three-state machine:
- `ST_IDLE`: the pin shows the idle level.
- `ST_PHASE0`: the first phase of the current item is driven.
- `ST_PHASE1`: the second phase of the current item is driven.

Its transitions are:
- launch: `ST_IDLE` to `ST_PHASE0`, on start when the fetched item has a non-zero first duration.
- empty start: stays in `ST_IDLE` and raises the end event, on start when the fetched first duration is zero.
- hop: `ST_PHASE0` to `ST_PHASE1`.
- short stop: `ST_PHASE0` to `ST_IDLE`, when the second duration is zero.
- chain: `ST_PHASE1` to `ST_PHASE0` of the next item.
- stop: `ST_PHASE1` to `ST_IDLE`, when the next item has a zero first duration, or when memory ends outside continuous mode.

Top module: `pulse_item_tx`

## Requirements
- R1: An item word holds the first duration in bits 14:0, the first level in bit 15, the second duration in bits 30:16 and the second level in bit 31. The first phase is driven before the second.
- R2: Each phase drives its level for exactly duration × divisor clock cycles. The first phase of the first item starts in the cycle after the clock edge that samples the start strobe. Consecutive items follow each other with no gap.
- R3: A `cfg_div` value from 1 to 255 divides by that value, and 0 divides by 256.
- R4: A phase with zero duration ends playback: an all-zero word after the last item, or a zero second duration inside an item. The pin shows the idle level from the cycle after the last driven phase, and event bit 0 (end) is set.
- R5: Outside playback, the pin equals `cfg_idle_lvl` when `cfg_idle_en` is 1, and is low when `cfg_idle_en` is 0.
- R6: When the carrier is enabled, any phase whose level equals `cfg_car_lvl` is chopped. The pin shows the phase level for `cfg_car_high` cycles, then its inverse for `cfg_car_low` cycles, and this repeats, starting with the high part. Phases of the other level are driven plainly.
- R7: Event bit 1 (threshold) is set when the number of items completed since start reaches a non-zero `cfg_limit`. The count then restarts. A `cfg_limit` of 0 never sets it.
- R8: With `cfg_conti` at 1, the read pointer wraps from the last memory word to word 0 and playback goes on. With `cfg_conti` at 0, playback ends after the last memory word, with the end event.
- R9: Each `mem_we` pulse writes `mem_wdata` at the write pointer, and then the pointer increments. `wr_ptr_rst` returns the pointer to 0. Writes during playback take effect without disturbing the output.
- R10: Start plays from the current read pointer. After playback ends on a zero word, the pointer stays on that word. `rd_ptr_rst` while idle returns the pointer to 0.
- R11: A start strobe during playback is ignored by the output and sets event bit 2 (error).
- R12: The event bits are sticky until cleared by a 1 on the matching `int_clr` bit. `irq` is high exactly when some event bit and its `int_ena` bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Tick divisor (0 means 256) |
| cfg_conti | input | 1 | Continuous wrap mode |
| cfg_idle_en | input | 1 | Idle level enable |
| cfg_idle_lvl | input | 1 | Idle level |
| cfg_car_en | input | 1 | Carrier enable |
| cfg_car_lvl | input | 1 | Phase level that receives the carrier |
| cfg_car_high | input | CAR_W | Carrier high-part length, in cycles |
| cfg_car_low | input | CAR_W | Carrier low-part length, in cycles |
| cfg_limit | input | LIMIT_W | Item-count threshold (0 disables) |
| mem_we | input | 1 | Item memory write strobe |
| mem_wdata | input | 32 | Item word to write |
| wr_ptr_rst | input | 1 | Write pointer reset pulse |
| rd_ptr_rst | input | 1 | Read pointer reset pulse (used while idle) |
| start | input | 1 | Start strobe |
| int_ena | input | 3 | Event enables {error, threshold, end} |
| int_clr | input | 3 | Write-1-to-clear for the event bits |
| tx_out | output | 1 | Output pin |
| irq | output | 1 | Interrupt line |
| raw_status | output | 3 | Sticky events {error, threshold, end} |

## Verification
The bench builds the block with 8-word blocks and two of them, so the item memory is only 16 words deep. With that depth, a continuous-mode wrap and a stop at the end of memory each take a few dozen cycles. A rewrite of word 0 while the first pass is still playing can then be seen on the second pass. The divide-by-256 encoding stays reachable with single-tick phases of about 500 cycles in all.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int DUR_W = 15;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PHASE0 = 2'd1,
        ST_PHASE1 = 2'd2
    } pit_state_e;

    // Word layout: second phase in the upper half, first phase in the lower half
    typedef struct packed {
        logic             lvl1;
        logic [DUR_W-1:0] dur1;
        logic             lvl0;
        logic [DUR_W-1:0] dur0;
    } pit_item_t;
endpackage

// File: rtl/pit_divider.sv
module pit_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] term;

    // 0 - 1 wraps to all ones, giving the maximum divisor
    assign term = div - DIV_W'(1);
    assign tick = run && (cnt == term);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (!run || tick) cnt <= '0;
        else                   cnt <= cnt + DIV_W'(1);
    end
endmodule

// File: rtl/pit_carrier.sv
module pit_carrier #(
    parameter int CAR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CAR_W-1:0] high_cnt,
    input  logic [CAR_W-1:0] low_cnt,
    output logic             car_hi
);
    logic [CAR_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            car_hi <= 1'b1;
        end else if (!en) begin
            cnt    <= '0;
            car_hi <= 1'b1;
        end else if (car_hi) begin
            if (cnt == high_cnt - CAR_W'(1)) begin
                cnt    <= '0;
                car_hi <= 1'b0;
            end else begin
                cnt <= cnt + CAR_W'(1);
            end
        end else begin
            if (cnt == low_cnt - CAR_W'(1)) begin
                cnt    <= '0;
                car_hi <= 1'b1;
            end else begin
                cnt <= cnt + CAR_W'(1);
            end
        end
    end
endmodule

// File: rtl/pit_item_mem.sv
module pit_item_mem #(
    parameter int DEPTH  = 64,
    parameter int PTR_W  = 6,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    // Asynchronous read lets the sequencer prefetch the next item without a gap
    assign rdata = store[raddr];
endmodule

// File: rtl/pulse_item_tx.sv
module pulse_item_tx
    import pit_pkg::*;
#(
    parameter int BLOCK_WORDS = 64,
    parameter int NUM_BLOCKS  = 1,
    parameter int DIV_W       = 8,
    parameter int CAR_W       = 16,
    parameter int LIMIT_W     = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic               cfg_conti,
    input  logic               cfg_idle_en,
    input  logic               cfg_idle_lvl,
    input  logic               cfg_car_en,
    input  logic               cfg_car_lvl,
    input  logic [CAR_W-1:0]   cfg_car_high,
    input  logic [CAR_W-1:0]   cfg_car_low,
    input  logic [LIMIT_W-1:0] cfg_limit,
    input  logic               mem_we,
    input  logic [31:0]        mem_wdata,
    input  logic               wr_ptr_rst,
    input  logic               rd_ptr_rst,
    input  logic               start,
    input  logic [2:0]         int_ena,
    input  logic [2:0]         int_clr,
    output logic               tx_out,
    output logic               irq,
    output logic [2:0]         raw_status
);
    localparam int DEPTH = BLOCK_WORDS * NUM_BLOCKS;
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    pit_state_e         state_q, state_d;
    pit_item_t          item_q, fetch_item;
    logic [31:0]        fetch_word;
    logic [PTR_W-1:0]   rd_ptr, wr_ptr, next_ptr, fetch_ptr;
    logic [DUR_W-1:0]   phase_cnt;
    logic [LIMIT_W-1:0] sent_cnt, sent_nx;
    logic               tick, busy, load, hop, finish, item_done;
    logic               cur_lvl, car_gate, car_hi, thr_hit, err_set;

    assign busy       = (state_q != ST_IDLE);
    assign next_ptr   = (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
    assign fetch_ptr  = busy ? next_ptr : rd_ptr;
    assign fetch_item = pit_item_t'(fetch_word);

    pit_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(busy), .div(cfg_div), .tick(tick)
    );

    pit_item_mem #(.DEPTH(DEPTH), .PTR_W(PTR_W), .WORD_W(32)) u_mem (
        .clk(clk), .we(mem_we), .waddr(wr_ptr), .wdata(mem_wdata),
        .raddr(fetch_ptr), .rdata(fetch_word)
    );

    pit_carrier #(.CAR_W(CAR_W)) u_car (
        .clk(clk), .rst_n(rst_n), .en(car_gate),
        .high_cnt(cfg_car_high), .low_cnt(cfg_car_low), .car_hi(car_hi)
    );

    // Next-state and sequencing strobes
    always_comb begin
        state_d   = state_q;
        load      = 1'b0;
        hop       = 1'b0;
        finish    = 1'b0;
        item_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    load = 1'b1;
                    if (fetch_item.dur0 == '0) finish  = 1'b1;
                    else                       state_d = ST_PHASE0;
                end
            end
            ST_PHASE0: begin
                if (tick && phase_cnt == item_q.dur0 - DUR_W'(1)) begin
                    if (item_q.dur1 == '0) begin
                        finish  = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        hop     = 1'b1;
                        state_d = ST_PHASE1;
                    end
                end
            end
            ST_PHASE1: begin
                if (tick && phase_cnt == item_q.dur1 - DUR_W'(1)) begin
                    item_done = 1'b1;
                    if ((rd_ptr == LAST && !cfg_conti) || fetch_item.dur0 == '0) begin
                        finish  = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        load    = 1'b1;
                        state_d = ST_PHASE0;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign sent_nx = sent_cnt + LIMIT_W'(1);
    assign thr_hit = item_done && (cfg_limit != '0) && (sent_nx == cfg_limit);
    assign err_set = start && busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            item_q     <= '0;
            rd_ptr     <= '0;
            wr_ptr     <= '0;
            phase_cnt  <= '0;
            sent_cnt   <= '0;
            raw_status <= '0;
        end else begin
            if (load) item_q <= fetch_item;

            if (item_done)             rd_ptr <= next_ptr;
            else if (rd_ptr_rst && !busy) rd_ptr <= '0;

            if (wr_ptr_rst)  wr_ptr <= '0;
            else if (mem_we) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);

            if (load || hop) phase_cnt <= '0;
            else if (tick)   phase_cnt <= phase_cnt + DUR_W'(1);

            if (!busy && start) sent_cnt <= '0;
            else if (thr_hit)   sent_cnt <= '0;
            else if (item_done) sent_cnt <= sent_nx;

            raw_status <= (raw_status & ~int_clr) | {err_set, thr_hit, finish};
        end
    end

    // Output process: pin level and interrupt
    always_comb begin
        cur_lvl  = (state_q == ST_PHASE0) ? item_q.lvl0 : item_q.lvl1;
        car_gate = cfg_car_en && busy && (cur_lvl == cfg_car_lvl);
        if (!busy)         tx_out = cfg_idle_en & cfg_idle_lvl;
        else if (car_gate) tx_out = car_hi ? cur_lvl : ~cur_lvl;
        else               tx_out = cur_lvl;
        irq = |(raw_status & int_ena);
    end
endmodule

// File: rtl/pit_checker.sv
module pit_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       tick,
    input logic       start,
    input logic       cfg_car_en,
    input logic       limit_nz,
    input logic [2:0] int_clr,
    input logic [2:0] raw_status,
    input logic       tx_out,
    input logic       irq
);
    AST_END_MEANS_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_status[0]) |-> !busy);                                        // R4
    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(tick) && !cfg_car_en && !$past(cfg_car_en))
        |-> $stable(tx_out));                                                    // R2
    AST_THR_NEEDS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_status[1]) |-> $past(limit_nz));                               // R7
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_status[2]) |-> ($past(start) && $past(busy)));                 // R11
    AST_END_CLEARED_BY_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(raw_status[0]) |-> $past(int_clr[0]));                             // R12
    AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw_status != 3'b000));                                         // R12
endmodule

bind pulse_item_tx pit_checker u_chk (
    .clk(clk), .rst_n(rst_n), .busy(state_q != pit_pkg::ST_IDLE), .tick(tick),
    .start(start), .cfg_car_en(cfg_car_en), .limit_nz(cfg_limit != '0),
    .int_clr(int_clr), .raw_status(raw_status), .tx_out(tx_out), .irq(irq)
);

// File: tb/pulse_item_tx_test.sv
`timescale 1ns/1ps
module pulse_item_tx_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [7:0]  cfg_div = 8'd1;
    logic        cfg_conti = 0, cfg_idle_en = 0, cfg_idle_lvl = 0;
    logic        cfg_car_en = 0, cfg_car_lvl = 0;
    logic [15:0] cfg_car_high = 16'd2, cfg_car_low = 16'd3;
    logic [9:0]  cfg_limit = '0;
    logic        mem_we = 0;
    logic [31:0] mem_wdata = '0;
    logic        wr_ptr_rst = 0, rd_ptr_rst = 0, start = 0;
    logic [2:0]  int_ena = '0, int_clr = '0;
    logic        tx_out, irq;
    logic [2:0]  raw_status;

    int checks = 0;
    int errors = 0;
    logic        cap   [0:1023];
    logic        exp_w [0:1023];
    int          exp_len;
    logic [31:0] prog  [0:31];

    always #2 clk = ~clk;

    pulse_item_tx #(.BLOCK_WORDS(8), .NUM_BLOCKS(2)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_conti(cfg_conti),
        .cfg_idle_en(cfg_idle_en), .cfg_idle_lvl(cfg_idle_lvl),
        .cfg_car_en(cfg_car_en), .cfg_car_lvl(cfg_car_lvl),
        .cfg_car_high(cfg_car_high), .cfg_car_low(cfg_car_low),
        .cfg_limit(cfg_limit), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .wr_ptr_rst(wr_ptr_rst), .rd_ptr_rst(rd_ptr_rst), .start(start),
        .int_ena(int_ena), .int_clr(int_clr), .tx_out(tx_out), .irq(irq),
        .raw_status(raw_status)
    );

    function automatic logic [31:0] mk(input logic l0, input int d0, input logic l1, input int d1);
        return {l1, d1[14:0], l0, d0[14:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic put(input logic v, input int n);
        for (int i = 0; i < n; i++) begin
            exp_w[exp_len] = v;
            exp_len++;
        end
    endtask

    task automatic cmp_wave(input string req);
        int bad = -1;
        for (int i = 0; i < exp_len; i++)
            if (bad < 0 && cap[i] !== exp_w[i]) bad = i;
        checks++;
        if (bad >= 0) begin
            errors++;
            $display("FAIL %s: sample %0d actual %0b expected %0b", req, bad, cap[bad], exp_w[bad]);
        end
    endtask

    task automatic load_prog(input int n);
        @(negedge clk) wr_ptr_rst = 1;
        @(negedge clk) wr_ptr_rst = 0;
        for (int i = 0; i < n; i++) begin
            mem_we = 1; mem_wdata = prog[i];
            @(negedge clk);
        end
        mem_we = 0;
    endtask

    task automatic clear_all();
        int_clr = 3'b111;
        @(negedge clk) int_clr = 3'b000;
    endtask

    // Reset read pointer, then strobe start; returns at the first sample slot
    task automatic kick();
        @(negedge clk) rd_ptr_rst = 1;
        @(negedge clk) rd_ptr_rst = 0; start = 1;
        @(negedge clk) start = 0;
    endtask

    // kind 1: rewrite word 0 during capture; kind 2: extra start strobe
    task automatic capture(input int n, input int act, input int kind, input logic [31:0] w);
        for (int i = 0; i < n; i++) begin
            cap[i] = tx_out;
            if (kind == 1) begin
                if (i == act)     wr_ptr_rst = 1;
                if (i == act + 1) begin wr_ptr_rst = 0; mem_we = 1; mem_wdata = w; end
                if (i == act + 2) mem_we = 0;
            end
            if (kind == 2) begin
                if (i == act)     start = 1;
                if (i == act + 1) start = 0;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R5 idle pin after reset", tx_out, 1'b0);
        chk("R12 events clear after reset", raw_status, 3'b000);
        chk("R12 irq low after reset", irq, 1'b0);
    endtask

    task automatic t_basic();
        clear_all();
        prog[0] = mk(1, 3, 0, 2); prog[1] = mk(0, 1, 1, 4); prog[2] = 32'h0;
        load_prog(3);
        kick();
        capture(14, -1, 0, 0);
        exp_len = 0; put(1, 3); put(0, 2); put(0, 1); put(1, 4); put(0, 4);
        cmp_wave("R1 R2 layout and phase order");
        chk("R4 end event after zero word", raw_status[0], 1'b1);
        int_clr = 3'b001;
        @(negedge clk) int_clr = 3'b000;
        chk("R12 end cleared by write-1", raw_status[0], 1'b0);
    endtask

    task automatic t_divider();
        clear_all();
        cfg_div = 8'd3;
        prog[0] = mk(1, 2, 0, 1); prog[1] = 32'h0;
        load_prog(2);
        kick();
        capture(12, -1, 0, 0);
        exp_len = 0; put(1, 6); put(0, 3); put(0, 3);
        cmp_wave("R3 divide by 3");
        cfg_div = 8'd0;
        prog[0] = mk(1, 1, 0, 1);
        load_prog(2);
        kick();
        capture(520, -1, 0, 0);
        exp_len = 0; put(1, 256); put(0, 256); put(0, 8);
        cmp_wave("R3 zero means divide by 256");
        cfg_div = 8'd1;
    endtask

    task automatic t_short_stop();
        clear_all();
        prog[0] = mk(1, 2, 0, 0); prog[1] = mk(1, 5, 1, 5);
        load_prog(2);
        kick();
        capture(8, -1, 0, 0);
        exp_len = 0; put(1, 2); put(0, 6);
        cmp_wave("R4 zero second duration stops");
        chk("R4 end event on short stop", raw_status[0], 1'b1);
    endtask

    task automatic t_idle();
        clear_all();
        cfg_idle_en = 1; cfg_idle_lvl = 1;
        @(negedge clk);
        chk("R5 idle level high", tx_out, 1'b1);
        prog[0] = mk(0, 2, 0, 2); prog[1] = 32'h0;
        load_prog(2);
        kick();
        capture(6, -1, 0, 0);
        exp_len = 0; put(0, 4); put(1, 2);
        cmp_wave("R5 idle level around playback");
        cfg_idle_en = 0;
        @(negedge clk);
        chk("R5 idle disabled drives low", tx_out, 1'b0);
    endtask

    task automatic t_carrier();
        clear_all();
        cfg_car_en = 1; cfg_car_lvl = 1;
        prog[0] = mk(0, 2, 1, 10); prog[1] = 32'h0;
        load_prog(2);
        kick();
        capture(14, -1, 0, 0);
        exp_len = 0; put(0, 2);
        for (int k = 0; k < 2; k++) begin put(1, 2); put(0, 3); end
        put(0, 2);
        cmp_wave("R6 carrier on high phases");
        cfg_car_lvl = 0;
        prog[0] = mk(0, 4, 1, 10);
        load_prog(2);
        kick();
        capture(16, -1, 0, 0);
        exp_len = 0; put(0, 2); put(1, 2); put(1, 10); put(0, 2);
        cmp_wave("R6 carrier only on matching level");
        cfg_car_en = 0;
    endtask

    task automatic t_threshold();
        clear_all();
        int_ena = 3'b010;
        for (int i = 0; i < 3; i++) prog[i] = mk(1, 1, 0, 1);
        prog[3] = 32'h0;
        load_prog(4);
        cfg_limit = 10'd3;
        kick();
        capture(10, -1, 0, 0);
        chk("R7 threshold at limit", raw_status[1], 1'b1);
        chk("R12 irq from enabled threshold", irq, 1'b1);
        clear_all();
        cfg_limit = 10'd4;
        kick();
        capture(10, -1, 0, 0);
        chk("R7 limit above count stays quiet", raw_status[1], 1'b0);
        cfg_limit = 10'd0;
        kick();
        capture(10, -1, 0, 0);
        chk("R7 limit zero disables", raw_status[1], 1'b0);
        chk("R12 irq low with end not enabled", irq, 1'b0);
        int_ena = 3'b000;
    endtask

    task automatic t_conti();
        clear_all();
        for (int i = 0; i < 16; i++) prog[i] = mk(1, 1, 0, 1);
        load_prog(16);
        cfg_conti = 1;
        kick();
        capture(40, 10, 1, mk(1, 2, 0, 2));
        exp_len = 0;
        for (int k = 0; k < 16; k++) begin put(1, 1); put(0, 1); end
        put(1, 2); put(0, 2); put(1, 1); put(0, 1); put(1, 1); put(0, 1);
        cmp_wave("R8 R9 wrap and live rewrite");
        chk("R8 no end while wrapping", raw_status[0], 1'b0);
        cfg_conti = 0;
        for (int i = 0; i < 200 && !raw_status[0]; i++) @(negedge clk);
        chk("R8 end after leaving continuous mode", raw_status[0], 1'b1);
        clear_all();
        prog[0] = mk(1, 1, 0, 1);
        load_prog(16);
        kick();
        capture(36, -1, 0, 0);
        exp_len = 0;
        for (int k = 0; k < 16; k++) begin put(1, 1); put(0, 1); end
        put(0, 4);
        cmp_wave("R8 stop at memory end");
        chk("R8 end event at memory end", raw_status[0], 1'b1);
    endtask

    task automatic t_error();
        clear_all();
        prog[0] = mk(1, 4, 0, 4); prog[1] = 32'h0;
        load_prog(2);
        kick();
        capture(10, 2, 2, 0);
        exp_len = 0; put(1, 4); put(0, 4); put(0, 2);
        cmp_wave("R11 start during playback ignored");
        chk("R11 error event", raw_status[2], 1'b1);
    endtask

    task automatic t_pointer();
        clear_all();
        prog[0] = mk(1, 2, 0, 2); prog[1] = 32'h0;
        load_prog(2);
        kick();
        capture(6, -1, 0, 0);
        clear_all();
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        capture(4, -1, 0, 0);
        exp_len = 0; put(0, 4);
        cmp_wave("R10 start resumes at zero word");
        chk("R10 immediate end from zero word", raw_status[0], 1'b1);
        clear_all();
        kick();
        capture(6, -1, 0, 0);
        exp_len = 0; put(1, 2); put(0, 2); put(0, 2);
        cmp_wave("R10 read pointer reset replays");
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_divider();
        t_short_stop();
        t_idle();
        t_carrier();
        t_threshold();
        t_conti();
        t_error();
        t_pointer();
        summary();
        $finish;
    end
endmodule